// File: doc/BRIEF.md
# Write-Through Snoop Controller

This block sits next to the private write-through data cache of one processor tile and keeps that cache consistent with stores made by other bus masters. It watches the request phase of a shared bus (write flag, master identifier, address, write data and byte enables). It records a store from a foreign master as pending. The store is acted on only once the target memory has returned its completion acknowledge. At that point the cache reports through a tag probe whether it holds the address. On a hit the block queues one cache action. On a miss it discards the store.

A mode pin picks the coherence policy, sampled when the acknowledge is accepted. In invalidate mode the block drops the matching line. In update mode it rewrites the cached word with the new data under the store's byte enables. The cache is shared with the local core, so the block requests a local semaphore, issues its action as a one-cycle strobe in a cycle where the grant is high, and withdraws the request on the next cycle. The block tracks one pending store and one queued action. If an acknowledge arrives while an action is still waiting for the semaphore, the block raises a stall output and the bus must hold its acknowledge. The acknowledge counts only in a cycle where the stall is low.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset, `sem_req`, `cache_stb` and `bus_stall` are low.
- R2: A request with `bus_req_vld`=1, `bus_req_wr`=1 and `bus_req_id` different from `own_id` is latched as pending at the clock edge. From the next cycle `probe_addr` shows its address.
- R3: A request whose `bus_req_id` equals `own_id` is not latched. A later acknowledge causes no semaphore request and no cache action.
- R4: A request with `bus_req_wr`=0 (a read) is not latched and causes no cache action.
- R5: No semaphore request and no cache action occur between a latched request and its acknowledge. An accepted acknowledge with `probe_hit`=1 raises `sem_req` in the following cycle.
- R6: With `upd_mode`=0 at the accepted acknowledge, the strobe carries `cache_op`=0 (invalidate) and the pending address.
- R7: With `upd_mode`=1 at the accepted acknowledge, the strobe carries `cache_op`=1 (update), the pending address, data and byte enables.
- R8: An accepted acknowledge with `probe_hit`=0 discards the pending store. No semaphore request and no cache action follow.
- R9: `cache_stb` is high only in a cycle where `sem_gnt` is high. While the grant is low, `sem_req` stays high and no strobe is issued.
- R10: In the cycle after a strobe, `sem_req` is low.
- R11: `bus_stall` is high exactly while a store is pending and an earlier action still waits. An acknowledge seen with `bus_stall` high is not accepted. It is accepted in the first cycle it is held with `bus_stall` low.
- R12: The policy is fixed at the accepted acknowledge. A change of `upd_mode` while the action waits for the grant does not change `cache_op`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_mode | input | 1 | Policy: 0 invalidate, 1 update |
| own_id | input | ID_W | Identifier of this tile's core on the bus |
| bus_req_vld | input | 1 | Request phase valid |
| bus_req_wr | input | 1 | Request is a write |
| bus_req_id | input | ID_W | Originating master |
| bus_req_addr | input | ADDR_W | Request address |
| bus_req_data | input | DATA_W | Write data |
| bus_req_be | input | DATA_W/8 | Byte enables |
| bus_ack | input | 1 | Target completion acknowledge for the pending write |
| bus_stall | output | 1 | Back-pressure: acknowledge must be held |
| probe_addr | output | ADDR_W | Tag probe address (pending store) |
| probe_hit | input | 1 | Cache holds `probe_addr` (combinational) |
| sem_req | output | 1 | Local semaphore request |
| sem_gnt | input | 1 | Local semaphore grant |
| cache_stb | output | 1 | One-cycle cache action strobe |
| cache_op | output | 1 | 0 invalidate line, 1 update word |
| cache_addr | output | ADDR_W | Action address |
| cache_data | output | DATA_W | Update data |
| cache_be | output | DATA_W/8 | Update byte enables |

## Verification
A request is latched at the edge where it is presented, and `probe_addr` is valid from the cycle after it. An accepted acknowledge raises `sem_req` in the next cycle. If the grant is already high, `cache_stb` is high in that same cycle. `sem_req` falls one cycle after the strobe. `bus_stall` is combinational on the stored state and is checked in the cycle the acknowledge is held. Stimulus changes on the falling edge and every output is sampled on the falling edge after the edge that should produce it, so each check lands on the cycle given above.

// File: rtl/wt_snoop_pkg.sv
package wt_snoop_pkg;
  parameter int SNP_ADDR_W = 32;
  parameter int SNP_DATA_W = 32;
  localparam int SNP_BE_W  = SNP_DATA_W / 8;

  typedef enum logic {
    OP_INVAL  = 1'b0,
    OP_UPDATE = 1'b1
  } snp_op_e;

  typedef struct packed {
    logic [SNP_ADDR_W-1:0] addr;
    logic [SNP_DATA_W-1:0] data;
    logic [SNP_BE_W-1:0]   be;
  } snp_store_t;
endpackage

// File: rtl/wt_snoop_capture.sv
module wt_snoop_capture
  import wt_snoop_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] own_id,
  input  logic            req_vld,
  input  logic            req_wr,
  input  logic [ID_W-1:0] req_id,
  input  snp_store_t      req_store,
  input  logic            ack,
  input  logic            act_busy,
  output logic            pend_v,
  output snp_store_t      pend_store,
  output logic            ack_take,
  output logic            stall
);
  logic foreign_wr;

  assign foreign_wr = req_vld && req_wr && (req_id != own_id);
  assign stall      = pend_v && act_busy;
  assign ack_take   = ack && pend_v && !act_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v     <= 1'b0;
      pend_store <= '0;
    end else if (ack_take) begin
      pend_v <= 1'b0;
    end else if (!pend_v && foreign_wr) begin
      pend_v     <= 1'b1;
      pend_store <= req_store;
    end
  end

  // own-core stores never become pending
  p_own_filtered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_wr && req_id == own_id && !pend_v && !ack) |=> !pend_v);

  // a stalled acknowledge keeps the store pending
  p_stall_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && ack) |=> pend_v);
endmodule

// File: rtl/wt_snoop_action.sv
module wt_snoop_action
  import wt_snoop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       upd_mode,
  input  snp_store_t load_store,
  input  logic       sem_gnt,
  output logic       busy,
  output logic       sem_req,
  output logic       stb,
  output snp_op_e    op,
  output snp_store_t store
);
  logic act_v;

  assign busy    = act_v;
  assign sem_req = act_v;
  assign stb     = act_v && sem_gnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_v <= 1'b0;
      op    <= OP_INVAL;
      store <= '0;
    end else if (stb) begin
      act_v <= 1'b0;
    end else if (load && !act_v) begin
      act_v <= 1'b1;
      op    <= upd_mode ? OP_UPDATE : OP_INVAL;
      store <= load_store;
    end
  end

  p_stb_granted_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> (sem_gnt && sem_req));

  p_wait_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_req && !sem_gnt) |=> sem_req);

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !sem_req);

  p_op_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_req && !stb) |=> $stable(op));
endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl
  import wt_snoop_pkg::*;
#(
  parameter int ID_W   = 4,
  localparam int ADDR_W = SNP_ADDR_W,
  localparam int DATA_W = SNP_DATA_W,
  localparam int BE_W   = SNP_BE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_mode,
  input  logic [ID_W-1:0]   own_id,
  input  logic              bus_req_vld,
  input  logic              bus_req_wr,
  input  logic [ID_W-1:0]   bus_req_id,
  input  logic [ADDR_W-1:0] bus_req_addr,
  input  logic [DATA_W-1:0] bus_req_data,
  input  logic [BE_W-1:0]   bus_req_be,
  input  logic              bus_ack,
  output logic              bus_stall,
  output logic [ADDR_W-1:0] probe_addr,
  input  logic              probe_hit,
  output logic              sem_req,
  input  logic              sem_gnt,
  output logic              cache_stb,
  output logic              cache_op,
  output logic [ADDR_W-1:0] cache_addr,
  output logic [DATA_W-1:0] cache_data,
  output logic [BE_W-1:0]   cache_be
);
  snp_store_t req_store, pend_store, act_store;
  snp_op_e    act_op;
  logic       pend_v, ack_take, act_busy;

  assign req_store = '{addr: bus_req_addr, data: bus_req_data, be: bus_req_be};

  wt_snoop_capture #(.ID_W(ID_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .own_id    (own_id),
    .req_vld   (bus_req_vld),
    .req_wr    (bus_req_wr),
    .req_id    (bus_req_id),
    .req_store (req_store),
    .ack       (bus_ack),
    .act_busy  (act_busy),
    .pend_v    (pend_v),
    .pend_store(pend_store),
    .ack_take  (ack_take),
    .stall     (bus_stall)
  );

  assign probe_addr = pend_store.addr;

  wt_snoop_action u_action (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ack_take && probe_hit),
    .upd_mode  (upd_mode),
    .load_store(pend_store),
    .sem_gnt   (sem_gnt),
    .busy      (act_busy),
    .sem_req   (sem_req),
    .stb       (cache_stb),
    .op        (act_op),
    .store     (act_store)
  );

  assign cache_op   = act_op;
  assign cache_addr = act_store.addr;
  assign cache_data = act_store.data;
  assign cache_be   = act_store.be;

  // a miss on an accepted acknowledge leaves no semaphore request behind
  p_miss_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !probe_hit && !sem_req) |=> !sem_req);

  // a hit on an accepted acknowledge always requests the semaphore
  p_hit_request_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && probe_hit) |=> sem_req);
endmodule

// File: tb/test_wt_snoop_ctrl.sv
module test_wt_snoop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 4;

  logic        clk = 1'b0;
  logic        rst_n, upd_mode;
  logic [3:0]  own_id, bus_req_id;
  logic        bus_req_vld, bus_req_wr, bus_ack, bus_stall;
  logic [31:0] bus_req_addr, bus_req_data, probe_addr, cache_addr, cache_data;
  logic [3:0]  bus_req_be, cache_be;
  logic        probe_hit, sem_req, sem_gnt, cache_stb, cache_op;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_snoop_ctrl #(.ID_W(ID_W)) i_wt_snoop_ctrl (.*);

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_req_vld = 0; bus_req_wr = 0; bus_ack = 0;
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic issue(input logic wr, input logic [3:0] id,
                       input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_req_vld = 1; bus_req_wr = wr; bus_req_id = id;
    bus_req_addr = a; bus_req_data = d; bus_req_be = be;
    cyc();
    bus_req_vld = 0; bus_req_wr = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; idle(); upd_mode = 0; own_id = 4'h3; bus_req_id = 0;
    bus_req_addr = 0; bus_req_data = 0; bus_req_be = 0; probe_hit = 0; sem_gnt = 0;
    repeat (3) cyc();
    rst_n = 1; cyc();
    chk(sem_req, 0, "R1 sem_req");
    chk(cache_stb, 0, "R1 cache_stb");
    chk(bus_stall, 0, "R1 bus_stall");
  endtask

  task automatic t_invalidate();
    upd_mode = 0; sem_gnt = 1; probe_hit = 1;
    issue(1, 4'h5, 32'h0000_1040, 32'hDEAD_BEEF, 4'hF);
    chk(probe_addr, 32'h0000_1040, "R2 probe_addr");
    chk(sem_req, 0, "R5 no req before ack");
    chk(cache_stb, 0, "R5 no stb before ack");
    cyc();
    chk(sem_req, 0, "R5 still waiting ack");
    bus_ack = 1; cyc(); bus_ack = 0;
    chk(sem_req, 1, "R5 req after ack");
    chk(cache_stb, 1, "R6 stb");
    chk(cache_op, 0, "R6 op inval");
    chk(cache_addr, 32'h0000_1040, "R6 addr");
    cyc();
    chk(sem_req, 0, "R10 released");
    chk(cache_stb, 0, "R10 single strobe");
  endtask

  task automatic t_update();
    upd_mode = 1; sem_gnt = 1; probe_hit = 1;
    issue(1, 4'h7, 32'h0000_2208, 32'h1234_5678, 4'h6);
    bus_ack = 1; cyc(); bus_ack = 0;
    chk(cache_stb, 1, "R7 stb");
    chk(cache_op, 1, "R7 op update");
    chk(cache_addr, 32'h0000_2208, "R7 addr");
    chk(cache_data, 32'h1234_5678, "R7 data");
    chk(cache_be, 4'h6, "R7 be");
    cyc();
    chk(sem_req, 0, "R10 released after update");
  endtask

  task automatic t_own();
    upd_mode = 0; sem_gnt = 1; probe_hit = 1;
    issue(1, 4'h3, 32'h0000_3000, 32'h1, 4'hF);
    bus_ack = 1; cyc(); bus_ack = 0;
    chk(sem_req, 0, "R3 own write no req");
    chk(cache_stb, 0, "R3 own write no stb");
    cyc();
    chk(cache_stb, 0, "R3 own write no later stb");
  endtask

  task automatic t_read();
    issue(0, 4'h9, 32'h0000_4000, 32'h2, 4'hF);
    bus_ack = 1; cyc(); bus_ack = 0;
    chk(sem_req, 0, "R4 read no req");
    chk(cache_stb, 0, "R4 read no stb");
  endtask

  task automatic t_miss();
    probe_hit = 0; sem_gnt = 1;
    issue(1, 4'h1, 32'h0000_5000, 32'h3, 4'hF);
    bus_ack = 1; cyc(); bus_ack = 0;
    chk(sem_req, 0, "R8 miss no req");
    chk(cache_stb, 0, "R8 miss no stb");
    probe_hit = 1; bus_ack = 1; cyc(); bus_ack = 0;
    chk(sem_req, 0, "R8 entry dropped");
  endtask

  task automatic t_wait_gnt_mode();
    upd_mode = 1; sem_gnt = 0; probe_hit = 1;
    issue(1, 4'h2, 32'h0000_6010, 32'hCAFE_0000, 4'h3);
    bus_ack = 1; cyc(); bus_ack = 0;
    upd_mode = 0;
    chk(sem_req, 1, "R9 req held");
    chk(cache_stb, 0, "R9 no stb without gnt");
    cyc(); cyc();
    chk(sem_req, 1, "R9 req still held");
    chk(cache_stb, 0, "R9 still no stb");
    sem_gnt = 1; #1;
    chk(cache_stb, 1, "R9 stb with gnt");
    chk(cache_op, 1, "R12 op kept update");
    cyc();
    chk(sem_req, 0, "R10 release after wait");
  endtask

  task automatic t_stall();
    upd_mode = 0; sem_gnt = 0; probe_hit = 1;
    issue(1, 4'h4, 32'h0000_7000, 32'hA, 4'hF);
    bus_ack = 1; cyc(); bus_ack = 0;
    issue(1, 4'h6, 32'h0000_7100, 32'hB, 4'hC);
    chk(bus_stall, 1, "R11 stall while busy");
    bus_ack = 1; cyc();
    chk(bus_stall, 1, "R11 ack not taken");
    sem_gnt = 1; #1;
    chk(cache_addr, 32'h0000_7000, "R11 first action addr");
    cyc();
    chk(bus_stall, 0, "R11 stall cleared");
    cyc(); bus_ack = 0;
    chk(cache_stb, 1, "R11 second stb");
    chk(cache_addr, 32'h0000_7100, "R11 second addr");
    chk(cache_be, 4'hC, "R11 second be");
    cyc();
    chk(sem_req, 0, "R10 release after stall");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_invalidate();
        t_update();
        t_own();
        t_read();
        t_miss();
        t_wait_gnt_mode();
        t_stall();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule